// File: doc/BRIEF.md
# Read-Path ID Prefix Interconnect

This block is one stage of an on-chip read interconnect. Several requesters share a single responder. On the request side it picks one requester's read address channel at a time, by round robin, and forwards it. The forwarded read ID is widened: the requester's index is placed above its own ID bits. The responder therefore sees a unique tag for each requester, even when two requesters use the same local ID.

On the return side, every data beat carries that wide ID. The top index bits alone choose which requester receives the beat. They are stripped off, so the requester sees the ID it issued. Beats for different requesters may arrive in any order and may interleave beat by beat. The router follows the tag of each beat on its own.

A beat whose index names no requester is swallowed, with ready held high so the responder cannot stall. A sticky error flag records that such a beat arrived.

Top module: `rd_id_xbar`

## Requirements
- R1: The forwarded ID equals {requester index, requester ID}, with the index in the upper ceil(log2(N)) bits. Address and burst length pass through unchanged.
- R2: Arbitration is round robin. After a handshake with requester i, the search for the next winner starts at i+1 (mod N). Out of reset it starts at requester 0.
- R3: Once an address is offered and not yet accepted, the same requester stays selected until the handshake, even if other requesters raise valid.
- R4: Address ready is returned only to the selected requester, and only when it is valid. At most one requester sees ready.
- R5: A data beat with index k in the upper ID bits asserts valid only toward requester k. That requester receives the lower ID bits, data, response and last flag unchanged.
- R6: Ready toward the responder equals the ready of the requester selected by the current beat's index.
- R7: A beat whose index is N or larger reaches no requester and sees ready high. route_error goes high on the next clock edge and stays high until reset.
- R8: Consecutive beats may target different requesters, and each beat is routed only by its own tag.
- R9: Reset (rst_n low, asynchronous) clears route_error and returns the round-robin start to requester 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_arvalid | input | N_MST | Address valid per requester |
| m_arready | output | N_MST | Address ready per requester |
| m_araddr | input | N_MST*ADDR_W | Address per requester, requester i in slice i |
| m_arid | input | N_MST*MID_W | Read ID per requester |
| m_arlen | input | N_MST*8 | Burst length per requester |
| s_arvalid | output | 1 | Forwarded address valid |
| s_arready | input | 1 | Responder address ready |
| s_araddr | output | ADDR_W | Forwarded address |
| s_arid | output | MID_W+IDX_W | Widened ID |
| s_arlen | output | 8 | Forwarded burst length |
| s_rvalid | input | 1 | Responder data valid |
| s_rready | output | 1 | Ready toward responder |
| s_rid | input | MID_W+IDX_W | Wide ID of returning beat |
| s_rdata | input | DATA_W | Beat data |
| s_rresp | input | 2 | Beat response code |
| s_rlast | input | 1 | Last beat of burst |
| m_rvalid | output | N_MST | Data valid per requester |
| m_rready | input | N_MST | Data ready per requester |
| m_rid | output | N_MST*MID_W | Narrowed ID per requester |
| m_rdata | output | N_MST*DATA_W | Data per requester |
| m_rresp | output | N_MST*2 | Response per requester |
| m_rlast | output | N_MST | Last flag per requester |
| route_error | output | 1 | Sticky: a beat named no requester |

## Verification
The hardest case to reach is an out-of-range index. With two requesters every index value names a real requester, so that case cannot occur. The bench therefore builds the block with three requesters, which leaves index 3 unused, and drives that tag directly. A stalled address grant is the other case that needs care. The bench holds address ready low while a single requester is valid, waits one edge so the grant locks, and only then raises the other requesters' valids. If the grant had not locked, round robin would have picked a different requester at that point.

// File: rtl/rdx_pkg.sv
package rdx_pkg;
  localparam int LEN_W  = 8;
  localparam int RESP_W = 2;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rdx_rr_pick.sv
module rdx_rr_pick #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic [IW-1:0] pick,
  output logic          any
);
  // Scan from the farthest offset down, so the nearest valid one wins.
  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int off = N - 1; off >= 0; off--) begin
      int j;
      j = (int'(start) + off) % N;
      if (req[j]) begin
        pick = IW'(j);
        any  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rdx_ar_stage.sv
module rdx_ar_stage
  import rdx_pkg::*;
#(
  parameter int N      = 2,
  parameter int MID_W  = 4,
  parameter int ADDR_W = 32,
  localparam int IW    = idx_bits(N),
  localparam int SID_W = MID_W + IW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        m_arvalid,
  output logic [N-1:0]        m_arready,
  input  logic [N*ADDR_W-1:0] m_araddr,
  input  logic [N*MID_W-1:0]  m_arid,
  input  logic [N*LEN_W-1:0]  m_arlen,
  output logic                s_arvalid,
  input  logic                s_arready,
  output logic [ADDR_W-1:0]   s_araddr,
  output logic [SID_W-1:0]    s_arid,
  output logic [LEN_W-1:0]    s_arlen
);
  logic          lock_q, lock_d;
  logic [IW-1:0] gnt_q, gnt_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic [IW-1:0] pick, cur;
  logic          any, upd_en;

  rdx_rr_pick #(.N(N), .IW(IW)) u_pick (
    .req(m_arvalid), .start(ptr_q), .pick(pick), .any(any)
  );

  assign cur       = lock_q ? gnt_q : pick;
  assign s_arvalid = lock_q ? m_arvalid[cur] : any;
  assign s_araddr  = m_araddr[int'(cur)*ADDR_W +: ADDR_W];
  assign s_arlen   = m_arlen[int'(cur)*LEN_W +: LEN_W];
  assign s_arid    = {cur, m_arid[int'(cur)*MID_W +: MID_W]};

  for (genvar i = 0; i < N; i++) begin : g_rdy
    assign m_arready[i] = s_arready && m_arvalid[i] && (cur == IW'(i));
  end

  assign upd_en = s_arvalid;

  always_comb begin
    lock_d = lock_q;
    gnt_d  = gnt_q;
    ptr_d  = ptr_q;
    if (s_arready) begin
      lock_d = 1'b0;
      ptr_d  = (cur == IW'(N - 1)) ? '0 : cur + IW'(1);
    end else begin
      lock_d = 1'b1;
      gnt_d  = cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      gnt_q  <= '0;
      ptr_q  <= '0;
    end else if (upd_en) begin
      lock_q <= lock_d;
      gnt_q  <= gnt_d;
      ptr_q  <= ptr_d;
    end
  end

  a_r3_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (s_arvalid && !s_arready) |=> (s_arvalid && $stable(s_arid)));

  a_r4_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_arready));
endmodule

// File: rtl/rdx_r_router.sv
module rdx_r_router
  import rdx_pkg::*;
#(
  parameter int N      = 2,
  parameter int MID_W  = 4,
  parameter int DATA_W = 32,
  localparam int IW    = idx_bits(N),
  localparam int SID_W = MID_W + IW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_rvalid,
  output logic                s_rready,
  input  logic [SID_W-1:0]    s_rid,
  input  logic [DATA_W-1:0]   s_rdata,
  input  logic [RESP_W-1:0]   s_rresp,
  input  logic                s_rlast,
  output logic [N-1:0]        m_rvalid,
  input  logic [N-1:0]        m_rready,
  output logic [N*MID_W-1:0]  m_rid,
  output logic [N*DATA_W-1:0] m_rdata,
  output logic [N*RESP_W-1:0] m_rresp,
  output logic [N-1:0]        m_rlast,
  output logic                route_error
);
  logic [IW-1:0] tag;
  logic          hit;
  logic          err_q, err_d, err_en;

  assign tag = s_rid[SID_W-1 -: IW];
  assign hit = (int'(tag) < N);

  for (genvar i = 0; i < N; i++) begin : g_out
    assign m_rvalid[i]                    = s_rvalid && (tag == IW'(i));
    assign m_rid[i*MID_W +: MID_W]        = s_rid[MID_W-1:0];
    assign m_rdata[i*DATA_W +: DATA_W]    = s_rdata;
    assign m_rresp[i*RESP_W +: RESP_W]    = s_rresp;
    assign m_rlast[i]                     = s_rlast;
  end

  assign s_rready = hit ? m_rready[tag] : 1'b1;

  assign err_en = s_rvalid && !hit;
  assign err_d  = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign route_error = err_q;

  a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_rvalid));

  a_r6_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|(m_rvalid & m_rready)) |-> s_rready);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    route_error |=> route_error);

  a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !hit) |-> (m_rvalid == '0 && s_rready));
endmodule

// File: rtl/rd_id_xbar.sv
module rd_id_xbar
  import rdx_pkg::*;
#(
  parameter int N_MST  = 2,
  parameter int MID_W  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = idx_bits(N_MST),
  localparam int SID_W = MID_W + IDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_MST-1:0]         m_arvalid,
  output logic [N_MST-1:0]         m_arready,
  input  logic [N_MST*ADDR_W-1:0]  m_araddr,
  input  logic [N_MST*MID_W-1:0]   m_arid,
  input  logic [N_MST*LEN_W-1:0]   m_arlen,
  output logic                     s_arvalid,
  input  logic                     s_arready,
  output logic [ADDR_W-1:0]        s_araddr,
  output logic [SID_W-1:0]         s_arid,
  output logic [LEN_W-1:0]         s_arlen,
  input  logic                     s_rvalid,
  output logic                     s_rready,
  input  logic [SID_W-1:0]         s_rid,
  input  logic [DATA_W-1:0]        s_rdata,
  input  logic [RESP_W-1:0]        s_rresp,
  input  logic                     s_rlast,
  output logic [N_MST-1:0]         m_rvalid,
  input  logic [N_MST-1:0]         m_rready,
  output logic [N_MST*MID_W-1:0]   m_rid,
  output logic [N_MST*DATA_W-1:0]  m_rdata,
  output logic [N_MST*RESP_W-1:0]  m_rresp,
  output logic [N_MST-1:0]         m_rlast,
  output logic                     route_error
);
  rdx_ar_stage #(.N(N_MST), .MID_W(MID_W), .ADDR_W(ADDR_W)) u_ar (
    .clk(clk), .rst_n(rst_n),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
    .m_arid(m_arid), .m_arlen(m_arlen),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_arid(s_arid), .s_arlen(s_arlen)
  );

  rdx_r_router #(.N(N_MST), .MID_W(MID_W), .DATA_W(DATA_W)) u_r (
    .clk(clk), .rst_n(rst_n),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rid(s_rid),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rlast(s_rlast),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rid(m_rid),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast),
    .route_error(route_error)
  );

  // The index carried upward must name the requester that got the handshake.
  a_r1_prefix_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (s_arvalid && s_arready) |-> m_arready[s_arid[SID_W-1 -: IDX_W]]);
endmodule

// File: tb/tb_rd_id_xbar.sv
module tb_rd_id_xbar;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 3;
  localparam int MW = 4;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam int SW = MW + IW;

  // Vector layout: [12:7] wide id, [6:4] requester readies,
  // [3:1] expected requester valids, [0] expected responder ready.
  localparam logic [12:0] VEC [6] = '{
    {6'b00_0101, 3'b001, 3'b001, 1'b1},
    {6'b01_1010, 3'b001, 3'b010, 1'b0},
    {6'b01_1010, 3'b010, 3'b010, 1'b1},
    {6'b10_0011, 3'b100, 3'b100, 1'b1},
    {6'b10_0011, 3'b011, 3'b100, 1'b0},
    {6'b00_1111, 3'b110, 3'b001, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]    m_arvalid, m_arready;
  logic [N*AW-1:0] m_araddr;
  logic [N*MW-1:0] m_arid;
  logic [N*8-1:0]  m_arlen;
  logic            s_arvalid, s_arready;
  logic [AW-1:0]   s_araddr;
  logic [SW-1:0]   s_arid;
  logic [7:0]      s_arlen;
  logic            s_rvalid, s_rready, s_rlast;
  logic [SW-1:0]   s_rid;
  logic [DW-1:0]   s_rdata;
  logic [1:0]      s_rresp;
  logic [N-1:0]    m_rvalid, m_rready, m_rlast;
  logic [N*MW-1:0] m_rid;
  logic [N*DW-1:0] m_rdata;
  logic [N*2-1:0]  m_rresp;
  logic            route_error;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rd_id_xbar #(.N_MST(N), .MID_W(MW), .ADDR_W(AW), .DATA_W(DW)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [MW-1:0] id_of(input int i);
    return MW'(i * 5 + 1);
  endfunction

  task automatic check_grant(input string req, input int g);
    check(req, 32'(s_arvalid), 1);
    check(req, 32'(s_arid), 32'({IW'(g), id_of(g)}));
    check(req, 32'(s_araddr), 32'(16'h1000 * (g + 1)));
    check(req, 32'(s_arlen), 32'(g + 2));
  endtask

  initial begin
    rst_n = 1'b0;
    m_arvalid = '0; s_arready = 1'b0; s_rvalid = 1'b0; m_rready = '0;
    s_rid = '0; s_rdata = '0; s_rresp = '0; s_rlast = 1'b0;
    for (int i = 0; i < N; i++) begin
      m_arid[i*MW +: MW]  = id_of(i);
      m_araddr[i*AW +: AW] = AW'(16'h1000 * (i + 1));
      m_arlen[i*8 +: 8]   = 8'(i + 2);
    end
    repeat (2) @(negedge clk);
    #1;
    check("R9 reset error flag", 32'(route_error), 0);
    check("R9 reset no ar valid", 32'(s_arvalid), 0);
    check("R9 reset no r valid", 32'(m_rvalid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 / R1: all requesters valid, responder always ready
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      m_arvalid = '1; s_arready = 1'b1;
      #1;
      check_grant("R2 R1 round robin grant", k % N);
      check("R4 ready to winner", 32'(m_arready), 32'(1 << (k % N)));
    end

    // R3: stall with only requester 2 valid, then raise the others
    @(negedge clk);
    m_arvalid = 3'b100; s_arready = 1'b0;
    #1;
    check_grant("R3 stalled pick", 2);
    check("R4 no ready while stalled", 32'(m_arready), 0);
    @(negedge clk);
    m_arvalid = 3'b111;
    #1;
    check_grant("R3 grant held", 2);
    @(negedge clk);
    s_arready = 1'b1;
    #1;
    check("R4 ready to held winner", 32'(m_arready), 32'b100);
    @(negedge clk);
    #1;
    check_grant("R2 wrap after 2", 0);
    @(negedge clk);
    m_arvalid = '0; s_arready = 1'b0;

    // R5 R6 R8: interleaved beats from the vector table
    for (int v = 0; v < 6; v++) begin
      logic [12:0] e;
      int t;
      e = VEC[v];
      t = int'(e[12:11]);
      @(negedge clk);
      s_rvalid = 1'b1; s_rid = e[12:7]; m_rready = e[6:4];
      s_rdata = DW'(16'hA000 + v); s_rresp = 2'(v); s_rlast = v[0];
      #1;
      check("R5 R8 target valid", 32'(m_rvalid), 32'(e[3:1]));
      check("R6 responder ready", 32'(s_rready), 32'(e[0]));
      check("R5 narrowed id", 32'(m_rid[t*MW +: MW]), 32'(e[10:7]));
      check("R5 data", 32'(m_rdata[t*DW +: DW]), 32'(16'hA000 + v));
      check("R5 resp", 32'(m_rresp[t*2 +: 2]), 32'(v % 4));
      check("R5 last", 32'(m_rlast[t]), 32'(v % 2));
    end
    check("R7 no error yet", 32'(route_error), 0);

    // R7: tag 3 names no requester
    @(negedge clk);
    s_rid = 6'b11_0111; m_rready = 3'b000;
    #1;
    check("R7 dropped beat", 32'(m_rvalid), 0);
    check("R7 ready forced", 32'(s_rready), 1);
    @(negedge clk);
    s_rid = 6'b01_0001; m_rready = 3'b010;
    #1;
    check("R7 flag set", 32'(route_error), 1);
    @(negedge clk);
    s_rvalid = 1'b0;
    #1;
    check("R7 flag sticky", 32'(route_error), 1);

    // R9: asynchronous reset clears the flag
    rst_n = 1'b0;
    #1;
    check("R9 reset clears flag", 32'(route_error), 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_arvalid = 3'b110;
    #1;
    check_grant("R9 start restored", 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule